// File: doc/BRIEF.md
# External Trigger Input Conditioner

This block takes a raw, asynchronous trigger or clock pin and turns it into a clean single-cycle pulse in the system clock domain. A timer can then use that pulse as a counting clock or as a trigger. The pin is first brought into the clock domain by a two-stage synchronizer. An optional inversion then selects which pin edge counts as active. A digital filter follows, where a four-bit code sets how many consecutive samples a new level must hold before it is accepted. The active (rising, after inversion) edges of the filtered level are divided by 1, 2, 4 or 8, and each completed division emits one tick.

Configuration is static, set from the parent timer: an enable, the polarity bit, a two-bit divide select and the filter code. While the enable is low no tick is produced and the edge divider is held cleared. The synchronizer and filter keep tracking the pin, so the level present at enable time does not create a false edge.

Top module: `ext_trig_cond`

## Requirements
- R1: While reset is asserted and after its release with a quiet pin, `tick` is 0.
- R2: `tick` is never high in two consecutive cycles; each qualified active edge gives exactly one one-cycle tick.
- R3: With `invert`=0, divide select 0 and filter code 0, a rising pin edge driven before clock edge k gives `tick`=1 exactly after edge k+2 (three edges), and a falling edge gives no tick.
- R4: With `invert`=1 the falling pin edge is the active edge and the rising edge gives no tick.
- R5: With filter code N (0..15), a new level is accepted only after it has been sampled on N+1 consecutive cycles; the tick for an active edge then appears after the (N+3)-th clock edge following the pin change.
- R6: A pin excursion shorter than N+1 cycles with filter code N gives no tick.
- R7: Divide select values 0, 1, 2, 3 give ratios 1, 2, 4, 8: a tick is emitted on every ratio-th active edge counted from enable, the first on the ratio-th edge.
- R8: While `en`=0 no tick is produced and the edge divider is cleared, so counting restarts from zero when `en` returns to 1.
- R9: Every tick corresponds to the pin level, after optional inversion, having been active three cycles before the tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Path enable; low clears the edge divider and blocks ticks |
| invert | input | 1 | 1 makes the falling pin edge the active edge |
| div_sel | input | 2 | Edge divide select: 0→1, 1→2, 2→4, 3→8 |
| flt_code | input | 4 | Filter code; 0 means no filtering |
| pin | input | 1 | Asynchronous external trigger/clock pin |
| tick | output | 1 | One-cycle pulse per qualified divided active edge |

## Verification
The hardest case to reach is a pin excursion that lasts exactly one cycle less than the filter requires. It has to be told apart from one that lasts exactly long enough, and the filter counter's boundary sits between those two. The bench drives the pin on falling clock edges for counted numbers of cycles, 4 and then 5 with code 4, and samples the tick at a known edge. The divider restart is reached by leaving a partial count, dropping the enable, and showing that the edges already counted do not complete a division.

// File: rtl/ext_trig_pkg.sv
package ext_trig_pkg;
  localparam int FLT_W  = 4;                 // filter code width
  localparam int DIV_W  = 2;                 // divide select width
  localparam int PCNT_W = (1 << DIV_W) - 1;  // edge counter width, max ratio 2**(2**DIV_W-1)
  typedef logic [FLT_W-1:0]  flt_code_t;
  typedef logic [DIV_W-1:0]  div_sel_t;
  typedef logic [PCNT_W-1:0] pcnt_t;
endpackage

// File: rtl/etc_sync.sv
module etc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic ready_o
);
  logic [STAGES-1:0] sh_q, sh_n;
  logic [STAGES-1:0] vld_q, vld_n;

  always_comb begin
    sh_n  = {sh_q[STAGES-2:0], d_i};
    vld_n = {vld_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      vld_q <= '0;
    end else begin
      sh_q  <= sh_n;
      vld_q <= vld_n;
    end
  end

  assign q_o     = sh_q[STAGES-1];
  assign ready_o = vld_q[STAGES-1];
endmodule

// File: rtl/etc_filter.sv
module etc_filter
  import ext_trig_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ready_i,
  input  logic      lvl_i,
  input  flt_code_t code_i,
  output logic      rise_o
);
  logic      flt_q, flt_n;
  flt_code_t cnt_q, cnt_n;
  logic      diff, hit;

  always_comb begin
    diff   = lvl_i ^ flt_q;
    hit    = diff && (cnt_q >= code_i);
    flt_n  = flt_q;
    cnt_n  = cnt_q;
    rise_o = 1'b0;
    if (!ready_i) begin
      // synchronizer still filling: track the level, no edges
      flt_n = lvl_i;
      cnt_n = '0;
    end else if (!diff) begin
      cnt_n = '0;
    end else if (hit) begin
      flt_n  = lvl_i;
      cnt_n  = '0;
      rise_o = lvl_i;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      flt_q <= flt_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/etc_prescale.sv
module etc_prescale
  import ext_trig_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_i,
  input  div_sel_t div_sel_i,
  input  logic     evt_i,
  output logic     tick_o
);
  pcnt_t pcnt_q, pcnt_n, ratio_m1;
  logic  last, tick_n;

  always_comb begin
    ratio_m1 = pcnt_t'((32'd1 << div_sel_i) - 32'd1);
    last     = (pcnt_q >= ratio_m1);
    pcnt_n   = pcnt_q;
    tick_n   = 1'b0;
    if (!en_i) begin
      pcnt_n = '0;
    end else if (evt_i) begin
      tick_n = last;
      pcnt_n = last ? '0 : pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      tick_o <= 1'b0;
    end else begin
      pcnt_q <= pcnt_n;
      tick_o <= tick_n;
    end
  end
endmodule

// File: rtl/ext_trig_cond.sv
module ext_trig_cond
  import ext_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       invert,
  input  logic [1:0] div_sel,
  input  logic [3:0] flt_code,
  input  logic       pin,
  output logic       tick
);
  logic pin_s, sync_rdy, lvl, rise;

  etc_sync #(.STAGES(2)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (pin),
    .q_o    (pin_s),
    .ready_o(sync_rdy)
  );

  assign lvl = pin_s ^ invert;

  etc_filter i_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .ready_i(sync_rdy),
    .lvl_i  (lvl),
    .code_i (flt_code),
    .rise_o (rise)
  );

  etc_prescale i_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en),
    .div_sel_i(div_sel),
    .evt_i    (rise),
    .tick_o   (tick)
  );
endmodule

// File: rtl/ext_trig_cond_chk.sv
module ext_trig_cond_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic invert,
  input logic pin,
  input logic tick
);
  // R2: one-cycle pulses
  p_single_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R8: disabled path stays quiet
  p_dis_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick);

  // R8: a tick only follows an enabled cycle
  p_tick_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(en));

  // R9: tick traces back to the active pin level three cycles earlier
  p_active_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ($past(pin, 3) ^ $past(invert)));

  // R1: no tick while in reset
  always @(posedge clk) begin
    if (!rst_n) a_reset_quiet_r1: assert (!tick);
  end
endmodule

bind ext_trig_cond ext_trig_cond_chk i_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en    (en),
  .invert(invert),
  .pin   (pin),
  .tick  (tick)
);

// File: tb/test_ext_trig_cond.sv
`timescale 1ns/1ps
module test_ext_trig_cond;
  logic       clk = 1'b0;
  logic       rst_n, en, invert, pin;
  logic [1:0] div_sel;
  logic [3:0] flt_code;
  logic       tick;
  int total = 0, bad = 0, nticks = 0;
  logic prev_tick = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  ext_trig_cond i_ext_trig_cond (
    .clk(clk), .rst_n(rst_n), .en(en), .invert(invert),
    .div_sel(div_sel), .flt_code(flt_code), .pin(pin), .tick(tick)
  );

  // tick monitor, sampled away from the rising edge (R2 width check)
  always @(negedge clk) begin
    if (tick) nticks++;
    if (tick && prev_tick) begin
      bad++; total++;
      $display("FAIL R2: tick high two cycles, actual=11 expected=10");
    end
    prev_tick <= tick;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {invert, div_sel[1:0], flt_code[3:0], edges[5:0], exp_ticks[4:0]}
  localparam logic [17:0] VEC [0:6] = '{
    {1'b0, 2'd0, 4'd0,  6'd5,  5'd5},
    {1'b1, 2'd0, 4'd0,  6'd4,  5'd4},
    {1'b0, 2'd1, 4'd2,  6'd5,  5'd2},
    {1'b1, 2'd2, 4'd3,  6'd9,  5'd2},
    {1'b0, 2'd3, 4'd1,  6'd17, 5'd2},
    {1'b1, 2'd3, 4'd15, 6'd8,  5'd1},
    {1'b0, 2'd2, 4'd7,  6'd4,  5'd1}
  };

  task automatic edges(input int n, input logic inv);
    for (int i = 0; i < n; i++) begin
      pin = ~inv; cyc(20);
      pin = inv;  cyc(20);
    end
  endtask

  task automatic setup(input logic inv, input logic [1:0] d, input logic [3:0] c);
    en = 1'b0; invert = inv; div_sel = d; flt_code = c; pin = inv;
    cyc(30);
    en = 1'b1; cyc(2);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; invert = 1'b0; div_sel = '0; flt_code = '0; pin = 1'b0;
    cyc(3);
    chk("R1", int'(tick), 0);
    rst_n = 1'b1;
    cyc(5);
    chk("R1", int'(tick), 0);

    // table walk: R4 R5 R7
    for (int v = 0; v < 7; v++) begin
      setup(VEC[v][17], VEC[v][16:15], VEC[v][14:11]);
      nticks = 0;
      edges(int'(VEC[v][10:5]), VEC[v][17]);
      cyc(30);
      chk("R7", nticks, int'(VEC[v][4:0]));
    end

    // R3: exact latency with no filter, falling edge silent
    setup(1'b0, 2'd0, 4'd0);
    pin = 1'b1;
    cyc(2); chk("R3", int'(tick), 0);
    cyc(1); chk("R3", int'(tick), 1);
    cyc(1); chk("R3", int'(tick), 0);
    cyc(10); nticks = 0;
    pin = 1'b0; cyc(10);
    chk("R3", nticks, 0);

    // R4: inverted, rising edge silent
    setup(1'b1, 2'd0, 4'd0);
    nticks = 0;
    pin = 1'b0; cyc(10);
    chk("R4", nticks, 1);
    nticks = 0;
    pin = 1'b1; cyc(10);
    chk("R4", nticks, 0);

    // R5: latency with code 5 is 8 edges
    setup(1'b0, 2'd0, 4'd5);
    pin = 1'b1;
    cyc(7); chk("R5", int'(tick), 0);
    cyc(1); chk("R5", int'(tick), 1);
    cyc(1); chk("R5", int'(tick), 0);
    pin = 1'b0; cyc(20);

    // R6: code 4, 4-cycle glitch rejected, 5-cycle accepted
    setup(1'b0, 2'd0, 4'd4);
    nticks = 0;
    pin = 1'b1; cyc(4); pin = 1'b0; cyc(20);
    chk("R6", nticks, 0);
    pin = 1'b1; cyc(5); pin = 1'b0; cyc(20);
    chk("R6", nticks, 1);

    // R8: disable clears partial count, no ticks while off
    setup(1'b0, 2'd2, 4'd0);
    nticks = 0;
    edges(3, 1'b0);
    en = 1'b0; cyc(3);
    edges(2, 1'b0);
    chk("R8", nticks, 0);
    en = 1'b1; cyc(2);
    edges(3, 1'b0);
    chk("R8", nticks, 0);
    edges(1, 1'b0);
    chk("R8", nticks, 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule